// File: doc/BRIEF.md
# Hysteresis Threshold Comparator

This block watches a stream of sampled values, such as converter results, and drives one output that turns on when the signal climbs past an upper limit. The output turns off again only once the signal drops past a lower limit. Between the two limits the output keeps its last value. A slow or noisy input therefore gives one clean transition per excursion instead of a burst of toggles. Each transition is marked by a one-cycle event. The event can start a control action downstream.

The block offers two ways to move the comparison point between the limits. The direct mode keeps both limits in separate registers and selects the next one in the same cycle as the crossing. It always compares unsigned. The reload mode models one working threshold register that is rewritten with the other limit after a programmable transfer delay. It can compare in two's complement. While such a rewrite is outstanding, new samples are not evaluated. A setup where the lower limit is above the upper one is reported, and the output is frozen while it lasts.

Top module: `hyst_cmp_top`

## Requirements
- R1: After reset, cmp_out is 0, switch_pulse is 0 and the upper limit is the active threshold.
- R2: While cmp_out is 0, a valid sample strictly greater than the active upper threshold sets cmp_out to 1 at the next clock edge.
- R3: While cmp_out is 1, a valid sample strictly less than the active lower threshold clears cmp_out to 0 at the next clock edge.
- R4: A sample equal to the active threshold never changes cmp_out.
- R5: When smp_vld is 0, cmp_out keeps its value, whatever smp_data holds.
- R6: With mode_reload = 0, every comparison is unsigned, even when signed_en is 1.
- R7: With mode_reload = 1 and signed_en = 1, samples and thresholds are compared as two's complement numbers.
- R8: With mode_reload = 1, after a crossing the next reload_lat clock cycles ignore all samples. The working threshold is then rewritten with the other limit, and the next sample is compared against that limit.
- R9: With mode_reload = 1, a reload_lat of 0 behaves like a latency of 1: exactly one following sample cycle is ignored.
- R10: cfg_err is 1 while thr_lo is greater than thr_hi (compared with the signedness in effect), and while it is 1, cmp_out does not change.
- R11: switch_pulse is 1 for exactly the one cycle in which cmp_out holds a new value, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Qualifies smp_data for one cycle |
| smp_data | input | DW | Sample value |
| thr_hi | input | DW | Upper limit |
| thr_lo | input | DW | Lower limit |
| mode_reload | input | 1 | 0 = direct dual-register switch, 1 = delayed single-register reload |
| signed_en | input | 1 | Requests two's complement compares (honoured only in reload mode) |
| reload_lat | input | LATW | Reload delay in clock cycles (0 acts as 1) |
| cmp_out | output | 1 | Hysteresis comparison result |
| switch_pulse | output | 1 | One-cycle marker of a cmp_out change |
| cfg_err | output | 1 | Lower limit set above the upper limit |

## Verification
The assertions check the holding behaviours on every cycle: the output is frozen without a valid sample, during a pending reload and under a configuration error. They also check that the switch marker lines up with every output change, that a sample above the upper limit always sets the output, and that every reload start opens a wait window. Only the directed scenarios can show that the thresholds have the right values. These include equality at each limit, the difference between unsigned and two's complement reading of the same bit pattern, the exact number of ignored samples for a given latency including zero, and that the limit used after a reload is the other one.

// File: rtl/hyst_pkg.sv
package hyst_pkg;

    typedef enum logic {
        ACT_UPPER = 1'b0,
        ACT_LOWER = 1'b1
    } act_sel_e;

    typedef struct packed {
        logic gt;
        logic lt;
    } cmp_res_t;

    function automatic act_sel_e other_side(input act_sel_e s);
        return (s == ACT_UPPER) ? ACT_LOWER : ACT_UPPER;
    endfunction

endpackage

// File: rtl/hyst_mag_cmp.sv
module hyst_mag_cmp
    import hyst_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sgn,
    output cmp_res_t      res
);
    logic signed [DW:0] ax;
    logic signed [DW:0] bx;

    always_comb begin
        ax     = {sgn & a[DW-1], a};
        bx     = {sgn & b[DW-1], b};
        res.gt = (ax > bx);
        res.lt = (ax < bx);
    end
endmodule

// File: rtl/hyst_reload_ctl.sv
module hyst_reload_ctl
    import hyst_pkg::*;
#(
    parameter int DW   = 12,
    parameter int LATW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mode_reload,
    input  logic            fire,
    input  act_sel_e        sel_q,
    input  logic [DW-1:0]   thr_hi,
    input  logic [DW-1:0]   thr_lo,
    input  logic [LATW-1:0] lat,
    output logic [DW-1:0]   act_thr,
    output logic            busy
);
    localparam logic [LATW-1:0] LAT_ONE = LATW'(1);

    logic [LATW-1:0] cnt;
    logic [DW-1:0]   side_thr;

    assign side_thr = (sel_q == ACT_LOWER) ? thr_lo : thr_hi;
    assign busy     = mode_reload && (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            act_thr <= thr_hi;
        end else if (!mode_reload) begin
            cnt     <= '0;
            act_thr <= side_thr;
        end else if (fire) begin
            cnt <= (lat == '0) ? LAT_ONE : lat;
        end else if (cnt != '0) begin
            cnt <= cnt - LAT_ONE;
            if (cnt == LAT_ONE) begin
                act_thr <= side_thr;
            end
        end
    end

    assert_reload_window_opens_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_reload && fire) |=> (cnt != '0));

endmodule

// File: rtl/hyst_state.sv
module hyst_state
    import hyst_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fire,
    output act_sel_e sel_q,
    output logic     switch_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q        <= ACT_UPPER;
            switch_pulse <= 1'b0;
        end else begin
            if (fire) begin
                sel_q <= other_side(sel_q);
            end
            switch_pulse <= fire;
        end
    end

    assert_pulse_marks_change_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (switch_pulse == (sel_q != $past(sel_q))));

endmodule

// File: rtl/hyst_cmp_top.sv
module hyst_cmp_top
    import hyst_pkg::*;
#(
    parameter int DW   = 12,
    parameter int LATW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            smp_vld,
    input  logic [DW-1:0]   smp_data,
    input  logic [DW-1:0]   thr_hi,
    input  logic [DW-1:0]   thr_lo,
    input  logic            mode_reload,
    input  logic            signed_en,
    input  logic [LATW-1:0] reload_lat,
    output logic            cmp_out,
    output logic            switch_pulse,
    output logic            cfg_err
);
    act_sel_e      sel_q;
    logic          busy;
    logic          fire;
    logic          eff_sgn;
    logic [DW-1:0] act_thr;
    logic [DW-1:0] use_thr;
    cmp_res_t      smp_res;
    cmp_res_t      cfg_res;

    assign eff_sgn = mode_reload & signed_en;
    assign use_thr = mode_reload ? act_thr
                   : ((sel_q == ACT_LOWER) ? thr_lo : thr_hi);

    hyst_mag_cmp #(.DW(DW)) u_smp_cmp (
        .a   (smp_data),
        .b   (use_thr),
        .sgn (eff_sgn),
        .res (smp_res)
    );

    hyst_mag_cmp #(.DW(DW)) u_cfg_cmp (
        .a   (thr_lo),
        .b   (thr_hi),
        .sgn (eff_sgn),
        .res (cfg_res)
    );

    assign cfg_err = cfg_res.gt;
    assign fire    = smp_vld && !busy && !cfg_err
                   && ((sel_q == ACT_UPPER) ? smp_res.gt : smp_res.lt);

    hyst_state u_state (
        .clk          (clk),
        .rst          (rst),
        .fire         (fire),
        .sel_q        (sel_q),
        .switch_pulse (switch_pulse)
    );

    hyst_reload_ctl #(.DW(DW), .LATW(LATW)) u_reload (
        .clk         (clk),
        .rst         (rst),
        .mode_reload (mode_reload),
        .fire        (fire),
        .sel_q       (sel_q),
        .thr_hi      (thr_hi),
        .thr_lo      (thr_lo),
        .lat         (reload_lat),
        .act_thr     (act_thr),
        .busy        (busy)
    );

    assign cmp_out = (sel_q == ACT_LOWER);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(cmp_out));

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmp_out));

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> $stable(cmp_out));

    assert_rise_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && !busy && !cfg_err && !cmp_out && smp_res.gt) |=> cmp_out);

endmodule

// File: tb/sim_hyst_cmp_top.sv
`timescale 1ns/1ps
module sim_hyst_cmp_top;
    localparam int DW   = 12;
    localparam int LATW = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            smp_vld = 1'b0;
    logic [DW-1:0]   smp_data = '0;
    logic [DW-1:0]   thr_hi = 12'd2000;
    logic [DW-1:0]   thr_lo = 12'd1000;
    logic            mode_reload = 1'b0;
    logic            signed_en = 1'b0;
    logic [LATW-1:0] reload_lat = 4'd3;
    logic            cmp_out;
    logic            switch_pulse;
    logic            cfg_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    hyst_cmp_top #(.DW(DW), .LATW(LATW)) u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .mode_reload(mode_reload),
        .signed_en(signed_en), .reload_lat(reload_lat),
        .cmp_out(cmp_out), .switch_pulse(switch_pulse), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [DW-1:0] v);
        smp_vld  = 1'b1;
        smp_data = v;
        @(negedge clk);
        smp_vld  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 cmp_out after reset", int'(cmp_out), 0);
        check("R1 switch_pulse after reset", int'(switch_pulse), 0);
        check("R1 cfg_err after reset", int'(cfg_err), 0);
    endtask

    task automatic t_direct();
        drive(12'd2000);
        check("R4 equal to upper", int'(cmp_out), 0);
        drive(12'd2001);
        check("R2 above upper", int'(cmp_out), 1);
        check("R11 pulse on rise", int'(switch_pulse), 1);
        idle(1);
        check("R11 pulse lasts one cycle", int'(switch_pulse), 0);
        drive(12'd1500);
        check("R3 inside band holds", int'(cmp_out), 1);
        drive(12'd1000);
        check("R4 equal to lower", int'(cmp_out), 1);
        check("R11 no pulse without change", int'(switch_pulse), 0);
        drive(12'd999);
        check("R3 below lower", int'(cmp_out), 0);
        check("R11 pulse on fall", int'(switch_pulse), 1);
    endtask

    task automatic t_no_valid();
        smp_data = 12'd4000;
        idle(3);
        check("R5 no strobe no change", int'(cmp_out), 0);
        check("R5 no pulse", int'(switch_pulse), 0);
    endtask

    task automatic t_direct_unsigned();
        signed_en = 1'b1;
        thr_hi = 12'd100;
        thr_lo = 12'd50;
        idle(1);
        drive(12'hF00);
        check("R6 direct compares unsigned", int'(cmp_out), 1);
        drive(12'd10);
        check("R6 fall back", int'(cmp_out), 0);
    endtask

    task automatic t_reload_signed();
        thr_hi      = 12'd100;
        thr_lo      = 12'hF9C;
        mode_reload = 1'b1;
        signed_en   = 1'b1;
        reload_lat  = 4'd3;
        idle(2);
        check("R7 signed limits valid", int'(cfg_err), 0);
        drive(12'hF00);
        check("R7 negative sample below upper", int'(cmp_out), 0);
        drive(12'h065);
        check("R2 reload rise", int'(cmp_out), 1);
        for (int i = 0; i < 3; i++) begin
            drive(12'hF38);
            check("R8 sample ignored during reload", int'(cmp_out), 1);
        end
        drive(12'hFCE);
        check("R8 lower limit active after reload", int'(cmp_out), 1);
        drive(12'hF9B);
        check("R3 reload fall", int'(cmp_out), 0);
        idle(5);
    endtask

    task automatic t_lat_zero();
        reload_lat = 4'd0;
        drive(12'h065);
        check("R9 rise with zero latency", int'(cmp_out), 1);
        drive(12'hF38);
        check("R9 one sample ignored", int'(cmp_out), 1);
        drive(12'hF38);
        check("R9 next sample evaluated", int'(cmp_out), 0);
        idle(2);
    endtask

    task automatic t_cfg_err();
        mode_reload = 1'b0;
        signed_en   = 1'b0;
        thr_hi      = 12'd500;
        thr_lo      = 12'd600;
        idle(1);
        check("R10 error flagged", int'(cfg_err), 1);
        drive(12'd4000);
        check("R10 output held", int'(cmp_out), 0);
        check("R10 no pulse", int'(switch_pulse), 0);
        thr_lo = 12'd100;
        idle(1);
        check("R10 error cleared", int'(cfg_err), 0);
        drive(12'd4000);
        check("R10 resumes after fix", int'(cmp_out), 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direct();
        t_no_valid();
        t_direct_unsigned();
        t_reload_signed();
        t_lat_zero();
        t_cfg_err();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule